// File: doc/BRIEF.md
# Bus Aperture Address Decoder

This block sits behind a bus slave port and decides where each incoming 32-bit request goes. It holds three memory windows: a register-space window, a main-memory window and a slow-peripheral window. Each is a naturally aligned power-of-two region. Its size is fixed at boot from strap pins, and a host places it with configuration-register writes. Every request that falls inside a window is forwarded one cycle later as a one-hot target select plus the offset inside that window. Every other request produces a one-cycle discard pulse and no access.

Each request carries a flag that tells an external master from an internal one. External masters may not use the slow-peripheral window, so such requests are dropped. If a host misprograms the windows so that they overlap, a fixed priority picks the target: register space wins, then main memory, then the slow-peripheral window.

A small controller sequences the block through three named states:
- ST_BOOT is entered at reset. It captures the straps and always moves to ST_CLOSED on the next clock.
- ST_CLOSED leaves for ST_OPEN when decode-enable bit 0 is written as 1. While the controller is in ST_CLOSED, every request is discarded.
- ST_OPEN returns to ST_CLOSED when that bit is written as 0.

Top module: `aperture_decoder`

## Requirements
- R1: After reset every base register reads 0 and decoding is disabled (control register reads 0). While decoding is disabled, every valid request yields a discard pulse and tgt_sel stays 0.
- R2: Each window's 4-bit size code is captured from its strap on the first clock after reset is released. The window size is 64 KB shifted left by the code, and codes above 12 act as 12 (256 MB). Strap changes after that clock have no effect until the next reset.
- R3: Configuration offsets are fixed: 0x10 is the main-memory base, 0x14 is the register-space base, 0x18 is the slow-peripheral base, and bit 0 of 0x04 is decode enable. Any other offset reads 0.
- R4: Base-register bits below the window size are forced to zero and read back as zero. Writing all ones therefore reads back as the bitwise inverse of (size − 1).
- R5: A request that hits a window drives tgt_sel one-hot, with bit 0 for register space, bit 1 for main memory and bit 2 for the slow-peripheral window. tgt_offset equals the address minus the window base.
- R6: A valid request that hits no window yields discard = 1, tgt_sel = 0 and tgt_offset = 0.
- R7: A request with req_ext = 1 whose selected window is the slow-peripheral one is discarded.
- R8: When windows overlap, register space takes priority over main memory, and main memory takes priority over the slow-peripheral window.
- R9: Results appear exactly one clock after the request is sampled, and back-to-back requests are decoded one per cycle. A cycle without req_valid produces no select and no discard.
- R10: Windows may sit anywhere in the address space, including a base of 0 and the topmost aligned slot, and in any order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_reg_size | input | 4 | Size code for the register-space window |
| strap_mem_size | input | 4 | Size code for the main-memory window |
| strap_slow_size | input | 4 | Size code for the slow-peripheral window |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_addr (combinational) |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Request address |
| req_ext | input | 1 | 1 = request from an external master |
| tgt_sel | output | 3 | One-hot target select, registered |
| tgt_offset | output | 32 | Offset inside the selected window |
| discard | output | 1 | Pulse: the request was dropped |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, a 64 KB minimum window and a maximum code of 12. It straps three different sizes, 64 KB, 1 MB, and a code of 15 that must clamp to 256 MB. Together these sizes reach the smallest window, an intermediate one and the saturated largest one. The spread makes alignment masking, all-ones size discovery, edge-of-window misses, overlap priority and a window sitting at the top of the address space all observable at the ports.

// File: rtl/aperture_pkg.sv
package aperture_pkg;

    typedef enum logic [1:0] {
        ST_BOOT   = 2'd0,
        ST_CLOSED = 2'd1,
        ST_OPEN   = 2'd2
    } dec_state_t;

    localparam int NUM_WIN  = 3;
    localparam int WIN_REG  = 0;
    localparam int WIN_MEM  = 1;
    localparam int WIN_SLOW = 2;

    localparam logic [7:0] CFG_CTRL_OFS = 8'h04;

    function automatic logic [7:0] win_cfg_offset(input int idx);
        case (idx)
            WIN_REG: return 8'h14;
            WIN_MEM: return 8'h10;
            default: return 8'h18;
        endcase
    endfunction

endpackage

// File: rtl/aperture_ctrl.sv
module aperture_ctrl
    import aperture_pkg::*;
#(
    parameter int CFG_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic              cfg_en_bit,
    output logic              capture,
    output logic              open
);

    localparam logic [CFG_AW-1:0] CTRL_ADDR = CFG_AW'(CFG_CTRL_OFS);

    dec_state_t state_q, state_d;
    logic       ctrl_wr;

    assign ctrl_wr = cfg_wr && (cfg_addr == CTRL_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:   state_d = ST_CLOSED;
            ST_CLOSED: if (ctrl_wr && cfg_en_bit)  state_d = ST_OPEN;
            ST_OPEN:   if (ctrl_wr && !cfg_en_bit) state_d = ST_CLOSED;
            default:   state_d = ST_BOOT;
        endcase
    end

    always_comb begin
        capture = (state_q == ST_BOOT);
        open    = (state_q == ST_OPEN);
    end

endmodule

// File: rtl/aperture_window.sv
module aperture_window #(
    parameter int              AW       = 32,
    parameter int              CFG_AW   = 8,
    parameter int              CODE_W   = 4,
    parameter int              MIN_LOG2 = 16,
    parameter int              MAX_CODE = 12,
    parameter logic [CFG_AW-1:0] CFG_OFS = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [CODE_W-1:0] strap,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [AW-1:0]     cfg_wdata,
    output logic [AW-1:0]     base_rd,
    input  logic [AW-1:0]     req_addr,
    output logic              hit,
    output logic [AW-1:0]     offset
);

    logic [CODE_W-1:0] size_code_q;
    logic [AW-1:0]     base_q;
    logic [AW-1:0]     hi_mask;

    assign hi_mask = {AW{1'b1}} << (MIN_LOG2 + int'(size_code_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_code_q <= '0;
        end else if (capture) begin
            size_code_q <= (int'(strap) > MAX_CODE) ? CODE_W'(MAX_CODE) : strap;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (cfg_wr && (cfg_addr == CFG_OFS)) begin
            base_q <= cfg_wdata & hi_mask;
        end
    end

    assign base_rd = base_q & hi_mask;
    assign hit     = ((req_addr & hi_mask) == base_q);
    assign offset  = req_addr & ~hi_mask;

    AST_SIZE_HELD: assert property (@(posedge clk) disable iff (!rst_n) !capture |=> $stable(size_code_q)); // R2

endmodule

// File: rtl/aperture_pick.sv
module aperture_pick
    import aperture_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       open,
    input  logic                       req_valid,
    input  logic                       req_ext,
    input  logic [NUM_WIN-1:0]         hit,
    input  logic [NUM_WIN-1:0][AW-1:0] offsets,
    output logic [NUM_WIN-1:0]         tgt_sel,
    output logic [AW-1:0]              tgt_offset,
    output logic                       discard
);

    logic [NUM_WIN-1:0] pick;
    logic [AW-1:0]      pick_off;
    logic               accept;

    // Fixed priority: lowest window index wins
    always_comb begin
        pick     = '0;
        pick_off = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit[i]) begin
                pick     = '0;
                pick[i]  = 1'b1;
                pick_off = offsets[i];
            end
        end
    end

    assign accept = req_valid && open && (pick != '0) && !(req_ext && pick[WIN_SLOW]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_sel    <= '0;
            tgt_offset <= '0;
            discard    <= 1'b0;
        end else begin
            tgt_sel    <= accept ? pick : '0;
            tgt_offset <= accept ? pick_off : '0;
            discard    <= req_valid && !accept;
        end
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(tgt_sel)); // R5
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n) ($past(rst_n) && $past(req_valid)) |-> ($countones({tgt_sel, discard}) == 1)); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) ($past(rst_n) && !$past(req_valid)) |-> (tgt_sel == '0 && !discard)); // R9
    AST_EXT_NO_SLOW: assert property (@(posedge clk) disable iff (!rst_n) $past(req_valid && req_ext) |-> !tgt_sel[WIN_SLOW]); // R7
    AST_CLOSED_DROPS: assert property (@(posedge clk) disable iff (!rst_n) ($past(rst_n) && $past(req_valid) && !$past(open)) |-> discard); // R1

endmodule

// File: rtl/aperture_decoder.sv
module aperture_decoder
    import aperture_pkg::*;
#(
    parameter int AW       = 32,
    parameter int CFG_AW   = 8,
    parameter int CODE_W   = 4,
    parameter int MIN_LOG2 = 16,
    parameter int MAX_CODE = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] strap_reg_size,
    input  logic [CODE_W-1:0] strap_mem_size,
    input  logic [CODE_W-1:0] strap_slow_size,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [AW-1:0]     cfg_wdata,
    output logic [AW-1:0]     cfg_rdata,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    input  logic              req_ext,
    output logic [NUM_WIN-1:0] tgt_sel,
    output logic [AW-1:0]     tgt_offset,
    output logic              discard
);

    logic                       capture;
    logic                       open;
    logic [NUM_WIN-1:0][CODE_W-1:0] straps;
    logic [NUM_WIN-1:0][AW-1:0] base_rd;
    logic [NUM_WIN-1:0][AW-1:0] offsets;
    logic [NUM_WIN-1:0]         hit;

    assign straps[WIN_REG]  = strap_reg_size;
    assign straps[WIN_MEM]  = strap_mem_size;
    assign straps[WIN_SLOW] = strap_slow_size;

    aperture_ctrl #(.CFG_AW(CFG_AW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_en_bit(cfg_wdata[0]),
        .capture   (capture),
        .open      (open)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        aperture_window #(
            .AW      (AW),
            .CFG_AW  (CFG_AW),
            .CODE_W  (CODE_W),
            .MIN_LOG2(MIN_LOG2),
            .MAX_CODE(MAX_CODE),
            .CFG_OFS (CFG_AW'(win_cfg_offset(w)))
        ) u_win (
            .clk      (clk),
            .rst_n    (rst_n),
            .capture  (capture),
            .strap    (straps[w]),
            .cfg_wr   (cfg_wr),
            .cfg_addr (cfg_addr),
            .cfg_wdata(cfg_wdata),
            .base_rd  (base_rd[w]),
            .req_addr (req_addr),
            .hit      (hit[w]),
            .offset   (offsets[w])
        );
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == CFG_AW'(CFG_CTRL_OFS)) cfg_rdata = AW'(open);
        for (int i = 0; i < NUM_WIN; i++) begin
            if (cfg_addr == CFG_AW'(win_cfg_offset(i))) cfg_rdata = base_rd[i];
        end
    end

    aperture_pick #(.AW(AW)) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .open      (open),
        .req_valid (req_valid),
        .req_ext   (req_ext),
        .hit       (hit),
        .offsets   (offsets),
        .tgt_sel   (tgt_sel),
        .tgt_offset(tgt_offset),
        .discard   (discard)
    );

endmodule

// File: tb/aperture_decoder_tb.sv
module aperture_decoder_tb;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [2:0]  sel;
        logic [31:0] off;
        logic        disc;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  strap_reg_size, strap_mem_size, strap_slow_size;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ext = 1'b0;
    logic [2:0]  tgt_sel;
    logic [31:0] tgt_offset;
    logic        discard;

    int checks = 0;
    int errors = 0;
    exp_t q[$];

    // Bench model state, from the requirements
    localparam logic [31:0] M_REG  = 32'hFFFF_0000; // 64 KB (code 0)
    localparam logic [31:0] M_MEM  = 32'hFFF0_0000; // 1 MB (code 4)
    localparam logic [31:0] M_SLOW = 32'hF000_0000; // 256 MB (code 15 -> 12)
    logic [31:0] b_reg = '0, b_mem = '0, b_slow = '0;
    logic        en = 1'b0;

    aperture_decoder u_dut (
        .clk(clk), .rst_n(rst_n),
        .strap_reg_size(strap_reg_size), .strap_mem_size(strap_mem_size),
        .strap_slow_size(strap_slow_size),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_ext(req_ext),
        .tgt_sel(tgt_sel), .tgt_offset(tgt_offset), .discard(discard)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic exp_t model(input logic [31:0] a, input logic ext, input string tag);
        exp_t e;
        e.sel = '0; e.off = '0; e.disc = 1'b1; e.tag = tag;
        if (en) begin
            if ((a & M_REG) == b_reg) begin
                e.sel = 3'b001; e.off = a & ~M_REG; e.disc = 1'b0;
            end else if ((a & M_MEM) == b_mem) begin
                e.sel = 3'b010; e.off = a & ~M_MEM; e.disc = 1'b0;
            end else if (((a & M_SLOW) == b_slow) && !ext) begin
                e.sel = 3'b100; e.off = a & ~M_SLOW; e.disc = 1'b0;
            end
        end
        return e;
    endfunction

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] a, input logic ext, input string tag);
        @(negedge clk);
        cfg_wr = 1'b0; req_valid = 1'b1; req_addr = a; req_ext = ext;
        q.push_back(model(a, ext, tag));
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; cfg_wr = 1'b0;
    endtask

    task automatic cfg_write(input logic [7:0] ofs, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b0; cfg_wr = 1'b1; cfg_addr = ofs; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        case (ofs)
            8'h04: en = d[0];
            8'h10: b_mem = d & M_MEM;
            8'h14: b_reg = d & M_REG;
            8'h18: b_slow = d & M_SLOW;
            default: ;
        endcase
    endtask

    task automatic cfg_read(input logic [7:0] ofs, input logic [31:0] exp, input string tag);
        @(negedge clk);
        req_valid = 1'b0; cfg_addr = ofs;
        #1;
        check32(tag, cfg_rdata, exp);
    endtask

    // Monitor: one clock after each sampled request, compare against the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n) begin
                if (q.size() > 0) begin
                    exp_t e;
                    e = q.pop_front();
                    checks++;
                    if (tgt_sel !== e.sel || tgt_offset !== e.off || discard !== e.disc) begin
                        errors++;
                        $display("FAIL %s: actual sel=%b off=%h disc=%b expected sel=%b off=%h disc=%b",
                                 e.tag, tgt_sel, tgt_offset, discard, e.sel, e.off, e.disc);
                    end
                end else begin
                    checks++;
                    if (tgt_sel !== 3'b000 || discard !== 1'b0) begin
                        errors++;
                        $display("FAIL R9 idle: actual sel=%b disc=%b expected sel=000 disc=0",
                                 tgt_sel, discard);
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        strap_reg_size  = 4'd0;
        strap_mem_size  = 4'd4;
        strap_slow_size = 4'd15;
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        check32("R1 sel in reset", {29'd0, tgt_sel}, 32'd0);
        check32("R1 discard in reset", {31'd0, discard}, 32'd0);
        rst_n = 1'b1;
        cfg_read(8'h14, 32'h0, "R1 reg base after reset");
        cfg_read(8'h10, 32'h0, "R1 mem base after reset");
        cfg_read(8'h18, 32'h0, "R1 slow base after reset");
        cfg_read(8'h04, 32'h0, "R1 disabled after reset");
        // R2: straps change after capture, must be ignored
        strap_reg_size = 4'd8; strap_mem_size = 4'd1; strap_slow_size = 4'd2;
        send(32'h0000_1000, 1'b0, "R1 disabled request discarded");
        idle();
        // R2/R4: size discovery by all-ones writes
        cfg_write(8'h14, 32'hFFFF_FFFF);
        cfg_write(8'h10, 32'hFFFF_FFFF);
        cfg_write(8'h18, 32'hFFFF_FFFF);
        cfg_read(8'h14, 32'hFFFF_0000, "R2 R4 reg window 64KB");
        cfg_read(8'h10, 32'hFFF0_0000, "R2 R4 mem window 1MB");
        cfg_read(8'h18, 32'hF000_0000, "R2 R4 slow window clamped 256MB");
        // R3/R4/R10: placement
        cfg_write(8'h14, 32'h1234_5678);
        cfg_write(8'h10, 32'h8000_0000);
        cfg_write(8'h18, 32'h0000_0000);
        cfg_read(8'h14, 32'h1234_0000, "R4 low bits forced zero");
        cfg_read(8'h08, 32'h0, "R3 unmapped offset reads zero");
        cfg_read(8'h10, 32'h8000_0000, "R3 offset 0x10 mem base");
        cfg_write(8'h04, 32'h1);
        cfg_read(8'h04, 32'h1, "R3 enable bit");
        // R5/R9: back-to-back hits
        send(32'h1234_ABCD, 1'b1, "R5 reg hit ext");
        send(32'h800F_FFFC, 1'b0, "R5 mem hit top edge");
        send(32'h0ABC_0000, 1'b0, "R5 R10 slow hit base zero");
        send(32'h0ABC_0000, 1'b1, "R7 ext slow discarded");
        send(32'h9000_0000, 1'b0, "R6 miss");
        send(32'h8010_0000, 1'b0, "R6 one past mem window");
        send(32'h1233_FFFF, 1'b0, "R6 one below reg window");
        idle();
        // R8: overlaps
        cfg_write(8'h14, 32'h0001_0000);
        cfg_write(8'h10, 32'h0000_0000);
        send(32'h0001_0004, 1'b0, "R8 reg over slow and mem");
        send(32'h0001_0004, 1'b1, "R8 R7 ext reg over slow kept");
        send(32'h0000_0010, 1'b0, "R8 mem over slow");
        send(32'h0020_0000, 1'b0, "R8 slow when alone");
        // R10: topmost slot
        cfg_write(8'h18, 32'hF000_0000);
        send(32'hFFFF_FFFF, 1'b0, "R10 top of space slow");
        send(32'hEFFF_FFFF, 1'b0, "R10 below top window misses");
        idle();
        // R1: disabling again
        cfg_write(8'h04, 32'h0);
        cfg_read(8'h04, 32'h0, "R1 R3 enable cleared");
        send(32'h0001_0004, 1'b0, "R1 disabled drops hit");
        idle();
        repeat (3) idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule